// File: doc/BRIEF.md
# Six-Digit Code Lock Controller

The block keeps a six-digit secret code and checks codes typed on a keypad against it. A keypad front end presents one BCD digit at a time with a valid strobe. A confirm strobe ends an attempt. In normal mode a confirmed entry of six digits that equals the stored code raises `open_o`. Any other confirmed entry is a failure: it raises `error_o` and increments a failure counter. On the third failure in a row the block locks out and ignores every input until the active-low reset is asserted. While `set_mode_i` is high, a confirmed entry of six digits replaces the stored code.

Control sits in a state machine with four states. READY waits for an entry. OPEN follows a correct code. WRONG follows a failed attempt. LOCKED is entered on the third failure and is left only through reset. The transitions are as follows:
- Any accepted digit moves READY, OPEN or WRONG to READY.
- A normal confirm moves to OPEN on a match. Otherwise it moves to WRONG, or to LOCKED when the count reaches three.
- A set-mode confirm moves to READY.
- Reset moves every state to READY.

Top module: `code_lock_ctrl`

## Requirements
- R1: After reset `open_o`, `error_o` and `locked_o` are 0, `fail_cnt_o` is 0, the entry buffer is empty, and the stored code is 000000.
- R2: A digit strobe with a value from 0 to 9 is appended to the entry. Only the first six digits are kept, and further digits are discarded.
- R3: A digit strobe with a value from 10 to 15 is ignored: the entry is unchanged and the outputs do not change.
- R4: A normal-mode confirm with six digits equal to the stored code sets `open_o` to 1 in the next cycle and clears `fail_cnt_o` to 0.
- R5: `open_o` and `error_o` stay high until the next accepted digit or reset.
- R6: A normal-mode confirm with a wrong code, or with fewer than six digits, sets `error_o` to 1 and increments `fail_cnt_o` by one.
- R7: When the third consecutive failure occurs, `locked_o` is 1, `error_o` is 1, `fail_cnt_o` is 3 and `open_o` is 0. Digits, confirms and set mode are then ignored.
- R8: A confirm while `set_mode_i` is 1 does no comparison and leaves `fail_cnt_o` unchanged. If six digits were entered, they become the stored code. With fewer digits the stored code is kept.
- R9: When a digit strobe and a confirm occur in the same cycle, the confirm acts and the digit is discarded.
- R10: Every confirm, in either mode, empties the entry buffer.
- R11: Reset leaves the locked-out state and restores the default code 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_i | input | 4 | Keyed digit value |
| digit_vld_i | input | 1 | Digit strobe, one cycle per key |
| set_mode_i | input | 1 | High to program a new code |
| confirm_i | input | 1 | Confirm strobe, ends an attempt |
| open_o | output | 1 | Correct code accepted |
| error_o | output | 1 | Last attempt failed |
| fail_cnt_o | output | 2 | Consecutive failed attempts |
| locked_o | output | 1 | Locked out until reset |

## Verification
Digit capture and code checking can fall in the same cycle, when the sixth digit arrives on the same edge as confirm. The bench provokes this by strobing a correct sixth digit together with confirm. It judges the outcome from the failure it expects: the digit must be dropped, so only five digits are compared, and a later correct entry must then open the lock. In the sweeps, a wrong digit is placed at every position, the invalid values 10 to 15 are tried, and the failure count is walked through every value up to lockout.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;
    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_OPEN   = 2'd1,
        ST_WRONG  = 2'd2,
        ST_LOCKED = 2'd3
    } lock_state_e;
endpackage

// File: rtl/code_lock_entry.sv
module code_lock_entry #(
    parameter int DIGITS  = 6,
    parameter int DIGIT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic                      clear_i,
    input  logic [DIGIT_W-1:0]        digit_i,
    output logic [DIGITS*DIGIT_W-1:0] code_o,
    output logic                      full_o
);
    localparam int CNT_W = $clog2(DIGITS + 1);

    logic [CNT_W-1:0]   count_q;
    logic [DIGIT_W-1:0] slot_q [DIGITS];
    logic               shift_en;

    assign full_o   = (count_q == CNT_W'(DIGITS));
    assign shift_en = push_i && !full_o && !clear_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (shift_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    // slot 0 holds the newest digit, slot DIGITS-1 the oldest
    for (genvar g = 0; g < DIGITS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (clear_i) begin
                slot_q[g] <= '0;
            end else if (shift_en) begin
                if (g == 0) slot_q[g] <= digit_i;
                else        slot_q[g] <= slot_q[(g > 0) ? g-1 : 0];
            end
        end
        assign code_o[g*DIGIT_W +: DIGIT_W] = slot_q[g];
    end
endmodule

// File: rtl/code_lock_store.sv
module code_lock_store #(
    parameter int CODE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code_o <= '0;
        else if (load_i) code_o <= code_i;
    end
endmodule

// File: rtl/code_lock_fsm.sv
module code_lock_fsm
    import code_lock_pkg::*;
#(
    parameter int MAX_FAILS = 3,
    parameter int FAIL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              digit_ok_i,
    input  logic              confirm_i,
    input  logic              set_mode_i,
    input  logic              full_i,
    input  logic              match_i,
    output logic              push_o,
    output logic              clear_o,
    output logic              load_o,
    output logic              open_o,
    output logic              error_o,
    output logic              locked_o,
    output logic [FAIL_W-1:0] fail_cnt_o
);
    lock_state_e       state_q, state_d;
    logic [FAIL_W-1:0] fail_q, fail_d, fail_inc;

    assign fail_inc = fail_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            fail_q  <= '0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
        end
    end

    always_comb begin
        state_d = state_q;
        fail_d  = fail_q;
        unique case (state_q)
            ST_READY, ST_OPEN, ST_WRONG: begin
                if (confirm_i) begin
                    if (set_mode_i) begin
                        state_d = ST_READY;
                    end else if (full_i && match_i) begin
                        state_d = ST_OPEN;
                        fail_d  = '0;
                    end else begin
                        fail_d  = fail_inc;
                        state_d = (fail_inc == FAIL_W'(MAX_FAILS)) ? ST_LOCKED : ST_WRONG;
                    end
                end else if (digit_ok_i) begin
                    state_d = ST_READY;
                end
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
        endcase
    end

    always_comb begin
        locked_o   = (state_q == ST_LOCKED);
        open_o     = (state_q == ST_OPEN);
        error_o    = (state_q == ST_WRONG) || locked_o;
        fail_cnt_o = fail_q;
        clear_o    = !locked_o && confirm_i;
        push_o     = !locked_o && digit_ok_i && !confirm_i;
        load_o     = clear_o && set_mode_i && full_i;
    end
endmodule

// File: rtl/code_lock_ctrl.sv
module code_lock_ctrl #(
    parameter int DIGITS    = 6,
    parameter int DIGIT_W   = 4,
    parameter int MAX_DIGIT = 9,
    parameter int MAX_FAILS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               digit_vld_i,
    input  logic               set_mode_i,
    input  logic               confirm_i,
    output logic               open_o,
    output logic               error_o,
    output logic [1:0]         fail_cnt_o,
    output logic               locked_o
);
    localparam int CODE_W = DIGITS * DIGIT_W;
    localparam int FAIL_W = 2;

    logic [CODE_W-1:0] entry_code, stored_code;
    logic              entry_full, digit_ok, match;
    logic              push, clear, load;

    assign digit_ok = digit_vld_i && (digit_i <= DIGIT_W'(MAX_DIGIT));
    assign match    = (entry_code == stored_code);

    code_lock_entry #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) entry_i (
        .clk(clk), .rst_n(rst_n), .push_i(push), .clear_i(clear),
        .digit_i(digit_i), .code_o(entry_code), .full_o(entry_full)
    );

    code_lock_store #(.CODE_W(CODE_W)) store_i (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .code_i(entry_code), .code_o(stored_code)
    );

    code_lock_fsm #(.MAX_FAILS(MAX_FAILS), .FAIL_W(FAIL_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .digit_ok_i(digit_ok), .confirm_i(confirm_i),
        .set_mode_i(set_mode_i), .full_i(entry_full), .match_i(match),
        .push_o(push), .clear_o(clear), .load_o(load),
        .open_o(open_o), .error_o(error_o), .locked_o(locked_o),
        .fail_cnt_o(fail_cnt_o)
    );
endmodule

// File: rtl/code_lock_ctrl_chk.sv
module code_lock_ctrl_chk #(
    parameter int DIGIT_W   = 4,
    parameter int MAX_DIGIT = 9,
    parameter int MAX_FAILS = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DIGIT_W-1:0] digit_i,
    input logic               digit_vld_i,
    input logic               set_mode_i,
    input logic               confirm_i,
    input logic               open_o,
    input logic               error_o,
    input logic [1:0]         fail_cnt_o,
    input logic               locked_o
);
    // R7: lockout persists until reset
    a_r7_locked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    // R7: outputs while locked
    a_r7_locked_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (!open_o && error_o && fail_cnt_o == 2'(MAX_FAILS)));

    // R4: opening always comes with a cleared count
    a_r4_open_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> (fail_cnt_o == 2'd0));

    // R6: a normal confirm either opens or bumps the count
    a_r6_confirm_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (confirm_i && !set_mode_i && !locked_o) |=>
            (open_o || fail_cnt_o == $past(fail_cnt_o) + 2'd1));

    // R8: set-mode confirm neither compares nor counts
    a_r8_set_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (confirm_i && set_mode_i && !locked_o) |=>
            (!open_o && !error_o && $stable(fail_cnt_o)));

    // R3: out-of-range digits have no effect on outputs
    a_r3_bad_digit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_vld_i && digit_i > DIGIT_W'(MAX_DIGIT) && !confirm_i) |=>
            ($stable(open_o) && $stable(error_o) && $stable(fail_cnt_o) && $stable(locked_o)));

    // R5: open and error are exclusive results
    a_r5_open_error_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_o && error_o));
endmodule

bind code_lock_ctrl code_lock_ctrl_chk #(
    .DIGIT_W(DIGIT_W), .MAX_DIGIT(MAX_DIGIT), .MAX_FAILS(MAX_FAILS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .digit_i(digit_i), .digit_vld_i(digit_vld_i),
    .set_mode_i(set_mode_i), .confirm_i(confirm_i), .open_o(open_o),
    .error_o(error_o), .fail_cnt_o(fail_cnt_o), .locked_o(locked_o)
);

// File: tb/code_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module code_lock_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit_i = '0;
    logic       digit_vld_i = 1'b0;
    logic       set_mode_i = 1'b0;
    logic       confirm_i = 1'b0;
    logic       open_o, error_o, locked_o;
    logic [1:0] fail_cnt_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [23:0] model_code;
    int  model_fails;

    always #2.5 clk = ~clk;

    code_lock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .digit_i(digit_i), .digit_vld_i(digit_vld_i),
        .set_mode_i(set_mode_i), .confirm_i(confirm_i), .open_o(open_o),
        .error_o(error_o), .fail_cnt_o(fail_cnt_o), .locked_o(locked_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_code  = '0;
        model_fails = 0;
    endtask

    task automatic key(input logic [3:0] d);
        @(negedge clk); digit_i = d; digit_vld_i = 1'b1;
        @(negedge clk); digit_vld_i = 1'b0;
    endtask

    task automatic confirm();
        @(negedge clk); confirm_i = 1'b1;
        @(negedge clk); confirm_i = 1'b0;
    endtask

    // enter the first n digits of c (most significant first)
    task automatic enter(input logic [23:0] c, input int n);
        for (int i = 0; i < n; i++) key(c[23-4*i -: 4]);
    endtask

    task automatic try_code(input logic [23:0] c);
        enter(c, 6);
        confirm();
    endtask

    task automatic check_state(input string tag, input int op, input int er, input int fc, input int lk);
        check({tag, " open"},   int'(open_o),     op);
        check({tag, " error"},  int'(error_o),    er);
        check({tag, " count"},  int'(fail_cnt_o), fc);
        check({tag, " locked"}, int'(locked_o),   lk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] bad;
        model_code = '0; model_fails = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 reset", 0, 0, 0, 0);

        // R1: default code 000000 opens
        try_code(24'h000000);
        check_state("R1 default code R4", 1, 0, 0, 0);

        // R3 sweep: invalid values keep open high
        for (int v = 10; v < 16; v++) begin
            key(4'(v));
            check("R3 invalid digit keeps open", int'(open_o), 1);
        end
        // R5: valid digit drops open
        key(4'd5);
        check("R5 digit clears open", int'(open_o), 0);
        confirm();   // 1 digit -> failure (R6 short entry)
        model_fails++;
        check_state("R6 short entry", 0, 1, model_fails, 0);

        // R8: program a new code (count unchanged)
        set_mode_i = 1'b1;
        enter(24'h409173, 6);
        confirm();
        set_mode_i = 1'b0;
        model_code = 24'h409173;
        check_state("R8 set confirm", 0, 0, model_fails, 0);
        try_code(model_code);
        model_fails = 0;
        check_state("R8 new code opens", 1, 0, 0, 0);

        // R6/R4 sweep: wrong digit at every position
        for (int pos = 0; pos < 6; pos++) begin
            for (int w = 1; w < 10; w += 4) begin
                bad = model_code;
                bad[23-4*pos -: 4] = 4'((int'(model_code[23-4*pos -: 4]) + w) % 10);
                try_code(bad);
                model_fails++;
                check_state("R6 wrong digit", 0, 1, model_fails, 0);
                if (model_fails == 2) begin
                    try_code(model_code);
                    model_fails = 0;
                    check_state("R4 correct clears count", 1, 0, 0, 0);
                end
            end
        end

        // R5: error held until a digit
        try_code(24'h000000);
        model_fails++;
        repeat (3) @(negedge clk);
        check("R5 error held", int'(error_o), 1);
        key(4'd1);
        check("R5 digit clears error", int'(error_o), 0);
        confirm();
        model_fails++;
        check("R6 count after short", int'(fail_cnt_o), 2);

        // R2: seventh digit discarded
        enter(model_code, 6);
        key(4'd8);
        confirm();
        model_fails = 0;
        check_state("R2 extra digit dropped", 1, 0, 0, 0);

        // R3: invalid digits interleaved are not stored
        for (int i = 0; i < 6; i++) begin
            key(4'(10 + i));
            key(model_code[23-4*i -: 4]);
        end
        confirm();
        check("R3 interleaved invalid", int'(open_o), 1);

        // R9: sixth digit together with confirm is dropped
        enter(model_code, 5);
        @(negedge clk); digit_i = model_code[3:0]; digit_vld_i = 1'b1; confirm_i = 1'b1;
        @(negedge clk); digit_vld_i = 1'b0; confirm_i = 1'b0;
        model_fails++;
        check_state("R9 confirm wins", 0, 1, model_fails, 0);

        // R10: buffer emptied by confirm
        enter(model_code, 3);
        confirm();
        model_fails++;
        check("R10 partial fails", int'(fail_cnt_o), model_fails);
        try_code(model_code);
        model_fails = 0;
        check("R10 buffer cleared", int'(open_o), 1);

        // R8: short set entry keeps code, count kept
        try_code(24'h111111);
        model_fails++;
        set_mode_i = 1'b1;
        enter(24'h2222ff, 4);
        confirm();
        set_mode_i = 1'b0;
        check_state("R8 short set", 0, 0, model_fails, 0);
        try_code(model_code);
        model_fails = 0;
        check("R8 old code kept", int'(open_o), 1);

        // R7: three failures lock
        for (int k = 1; k <= 3; k++) begin
            try_code(24'h999999);
            check("R7 count walk", int'(fail_cnt_o), k);
        end
        check_state("R7 locked", 0, 1, 3, 1);
        try_code(model_code);
        check_state("R7 correct ignored", 0, 1, 3, 1);
        set_mode_i = 1'b1;
        try_code(24'h555555);
        set_mode_i = 1'b0;
        check_state("R7 set ignored", 0, 1, 3, 1);

        // R11: reset leaves lockout, default code back
        do_reset();
        check_state("R11 after reset", 0, 0, 0, 0);
        try_code(24'h000000);
        check("R11 default restored", int'(open_o), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule